// File: doc/BRIEF.md
# Privilege-Aware Interrupt Arbiter

This block decides which interrupt, if any, a processor hart should take next. It keeps a register of pending interrupt causes and a separate non-maskable flag. Both are changed by single-number post and clear strobes, by a clear-all strobe, and by a bank of local interrupt pins. From the current privilege level, the global interrupt-enable bits of each level, the machine and supervisor delegation masks, and two flags that say whether the supervisor and user-trap extensions are present, it builds a per-cause global mask. It then picks one cause by fixed priority.

Selection is purely combinational from the registered pending state. A posted interrupt therefore becomes visible in the cycle after its strobe. Trap entry, vectoring and register access are outside this block: the owner of the control registers drives the level, status, delegation and enable inputs directly.

Causes 0 to 15 are the standard classes. Software interrupts are 0, 1 and 3, timers are 4, 5 and 7, and external interrupts are 8, 9 and 11, for the user, supervisor and machine levels in that order. Causes 16 and above are local causes.

Top module: `irq_arbiter`

## Requirements
- R1: At machine level (priv_lvl = 2'b11), st_mie = 1 opens causes 3, 7 and 11 and every local cause. The user-class causes 0, 4 and 8 and the supervisor-class causes 1, 5 and 9 are never selected at this level. With st_mie = 0 no cause is selected.
- R2: At supervisor level (priv_lvl = 2'b01), a machine-class or local cause whose mdeleg bit is 0 is always open. A cause whose mdeleg bit is 1 is open only when st_sie = 1. Supervisor-class causes are open only when st_sie = 1. User-class causes are never open.
- R3: At user level (priv_lvl = 2'b00) with has_s = 1, the sdeleg mask decides. Each machine-, supervisor-class or local cause with sdeleg = 0 is open. One with sdeleg = 1 is open only when st_uie = 1. User-class causes are open only when st_uie = 1.
- R4: At user level with has_s = 0, the mdeleg mask decides for machine-class and local causes in the same way, and supervisor-class causes are never open. User-class causes are open only when st_uie = 1.
- R5: mdeleg is treated as zero unless has_s or has_n is 1. sdeleg is treated as zero unless both are 1.
- R6: A pending non-maskable interrupt drives irq_valid = 1 and irq_nmi = 1 with irq_cause = 0, whatever the level, mask and enables.
- R7: A cause is a candidate only when its pending bit, its irq_en bit and its mask bit are all 1. The first candidate in this order is reported: 11, 3, 7, 9, 1, 5, 8, 0, 4, then 16 upward.
- R8: local_pin[n] high at a clock edge sets the pending bit of cause n+16. NUM_LOCAL may not exceed 48.
- R9: post_valid sets and clr_valid resets the pending bit named by post_num / clr_num. The number NMI_NUM (default 64) acts on the non-maskable flag instead. Any other number at or above 16+NUM_LOCAL is ignored. When the same cause is posted and cleared in one cycle, the post wins.
- R10: clr_all zeroes every pending bit and the non-maskable flag, overriding posts and pins in the same cycle.
- R11: The reserved level 2'b10 masks every cause and drives priv_err = 1. priv_err is 0 for the other levels.
- R12: After a synchronous reset, nothing is pending and irq_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| priv_lvl | input | 2 | Current level: 00 user, 01 supervisor, 11 machine, 10 reserved |
| st_mie | input | 1 | Machine global interrupt enable |
| st_sie | input | 1 | Supervisor global interrupt enable |
| st_uie | input | 1 | User global interrupt enable |
| has_s | input | 1 | Supervisor level is implemented |
| has_n | input | 1 | User-level trap extension is implemented |
| mdeleg | input | 16+NUM_LOCAL | Machine delegation mask |
| sdeleg | input | 16+NUM_LOCAL | Supervisor delegation mask |
| irq_en | input | 16+NUM_LOCAL | Per-cause enable |
| post_valid | input | 1 | Post strobe |
| post_num | input | NUM_W | Number to post |
| clr_valid | input | 1 | Clear strobe |
| clr_num | input | NUM_W | Number to clear |
| clr_all | input | 1 | Clear every pending bit and the non-maskable flag |
| local_pin | input | NUM_LOCAL | Local interrupt pins |
| irq_valid | output | 1 | An interrupt is selected |
| irq_nmi | output | 1 | The selection is the non-maskable interrupt |
| irq_cause | output | clog2(16+NUM_LOCAL) | Selected cause number |
| priv_err | output | 1 | Reserved level encoding seen |

## Verification
The main function is driven with one fixed pending pattern that covers all three causes of each class plus a few local causes. Level, status bits, extension flags, delegation masks and enables are then swept across a table of rows. The rows separate each level's rule for delegated and non-delegated causes. They show that the target level's enable opens a delegated cause, and that absent extensions really zero the delegation masks. Enable subsets that leave two or more candidates check the priority order inside each class and between standard and local causes. Directed cases cover posting and clearing the non-maskable number, out-of-range numbers, a post and clear of the same cause in one cycle, pins against clear-all, and reset.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
   typedef enum logic [1:0] {
      LVL_USER  = 2'b00,
      LVL_SUPER = 2'b01,
      LVL_RSVD  = 2'b10,
      LVL_MACH  = 2'b11
   } lvl_t;

   // standard cause classes inside causes 0..15
   localparam logic [15:0] CLS_MACH  = 16'h0888;
   localparam logic [15:0] CLS_SUPER = 16'h0222;
   localparam logic [15:0] CLS_USER  = 16'h0111;

   localparam int NUM_STD_ORDER = 9;
   localparam int LOCAL_BASE    = 16;

   // fixed priority among standard causes
   function automatic int std_order(input int k);
      case (k)
         0: std_order = 11;
         1: std_order = 3;
         2: std_order = 7;
         3: std_order = 9;
         4: std_order = 1;
         5: std_order = 5;
         6: std_order = 8;
         7: std_order = 0;
         default: std_order = 4;
      endcase
   endfunction
endpackage

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg #(
   parameter int NUM_LOCAL = 48,
   parameter int NUM_W     = 7,
   parameter int NMI_NUM   = 64,
   localparam int NC       = 16 + NUM_LOCAL
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 post_valid,
   input  logic [NUM_W-1:0]     post_num,
   input  logic                 clr_valid,
   input  logic [NUM_W-1:0]     clr_num,
   input  logic                 clr_all,
   input  logic [NUM_LOCAL-1:0] local_pin,
   output logic [NC-1:0]        pend_q,
   output logic                 nmi_q
);
   localparam logic [NUM_W-1:0] NC_N  = NUM_W'(NC);
   localparam logic [NUM_W-1:0] NMI_N = NUM_W'(NMI_NUM);

   logic [NC-1:0] pend_d;
   logic          nmi_d;

   always_comb begin
      pend_d = pend_q;
      nmi_d  = nmi_q;
      if (clr_valid) begin
         if (clr_num == NMI_N)     nmi_d = 1'b0;
         else if (clr_num < NC_N)  pend_d[clr_num] = 1'b0;
      end
      if (post_valid) begin
         if (post_num == NMI_N)    nmi_d = 1'b1;
         else if (post_num < NC_N) pend_d[post_num] = 1'b1;
      end
      pend_d[NC-1:16] = pend_d[NC-1:16] | local_pin;
      if (clr_all) begin
         pend_d = '0;
         nmi_d  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         nmi_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         nmi_q  <= nmi_d;
      end
   end
endmodule

// File: rtl/irq_mask_gen.sv
`timescale 1ns/1ps
module irq_mask_gen
   import irq_pkg::*;
#(
   parameter int NUM_LOCAL = 48,
   localparam int NC       = 16 + NUM_LOCAL
) (
   input  lvl_t          lvl,
   input  logic          st_mie,
   input  logic          st_sie,
   input  logic          st_uie,
   input  logic          has_s,
   input  logic          has_n,
   input  logic [NC-1:0] mdeleg,
   input  logic [NC-1:0] sdeleg,
   output logic [NC-1:0] gmask,
   output logic          bad_lvl
);
   logic [NC-1:0] loc_v, mach_v, sup_v, usr_v;
   logic [NC-1:0] md_eff, sd_eff;

   assign mach_v = NC'(CLS_MACH);
   assign sup_v  = NC'(CLS_SUPER);
   assign usr_v  = NC'(CLS_USER);

   for (genvar i = 0; i < NC; i++) begin : g_loc
      if (i >= LOCAL_BASE) begin : g_on
         assign loc_v[i] = 1'b1;
      end else begin : g_off
         assign loc_v[i] = 1'b0;
      end
   end

   assign md_eff = (has_s | has_n) ? mdeleg : '0;
   assign sd_eff = (has_s & has_n) ? sdeleg : '0;

   always_comb begin
      gmask   = '0;
      bad_lvl = 1'b0;
      unique case (lvl)
         LVL_MACH:
            gmask = st_mie ? (mach_v | loc_v) : '0;
         LVL_SUPER:
            gmask = ((mach_v | loc_v) & (~md_eff | {NC{st_sie}}))
                  | (st_sie ? sup_v : '0);
         LVL_USER:
            if (has_s)
               gmask = ((mach_v | sup_v | loc_v) & (~sd_eff | {NC{st_uie}}))
                     | (st_uie ? usr_v : '0);
            else
               gmask = ((mach_v | loc_v) & (~md_eff | {NC{st_uie}}))
                     | (st_uie ? usr_v : '0);
         default: begin
            gmask   = '0;
            bad_lvl = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel
   import irq_pkg::*;
#(
   parameter int NUM_LOCAL = 48,
   localparam int NC       = 16 + NUM_LOCAL,
   localparam int CW       = $clog2(NC),
   localparam int NORD     = NUM_STD_ORDER + NUM_LOCAL
) (
   input  logic [NC-1:0] cand,
   output logic          hit,
   output logic [CW-1:0] sel
);
   always_comb begin
      hit = 1'b0;
      sel = '0;
      // scan from lowest to highest priority, last match wins
      for (int k = NORD - 1; k >= 0; k--) begin
         int idx;
         idx = (k < NUM_STD_ORDER) ? std_order(k)
                                   : LOCAL_BASE + k - NUM_STD_ORDER;
         if (cand[idx]) begin
            hit = 1'b1;
            sel = CW'(idx);
         end
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int NUM_LOCAL = 48,
   parameter int NUM_W     = 7,
   parameter int NMI_NUM   = 64,
   localparam int NC       = 16 + NUM_LOCAL,
   localparam int CW       = $clog2(NC)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [1:0]           priv_lvl,
   input  logic                 st_mie,
   input  logic                 st_sie,
   input  logic                 st_uie,
   input  logic                 has_s,
   input  logic                 has_n,
   input  logic [NC-1:0]        mdeleg,
   input  logic [NC-1:0]        sdeleg,
   input  logic [NC-1:0]        irq_en,
   input  logic                 post_valid,
   input  logic [NUM_W-1:0]     post_num,
   input  logic                 clr_valid,
   input  logic [NUM_W-1:0]     clr_num,
   input  logic                 clr_all,
   input  logic [NUM_LOCAL-1:0] local_pin,
   output logic                 irq_valid,
   output logic                 irq_nmi,
   output logic [CW-1:0]        irq_cause,
   output logic                 priv_err
);
   if (NUM_LOCAL < 1 || NUM_LOCAL > 48) begin : g_bad_local
      $error("irq_arbiter: NUM_LOCAL must be 1..48");
   end
   if (NMI_NUM < NC || NMI_NUM >= (1 << NUM_W)) begin : g_bad_nmi
      $error("irq_arbiter: NMI_NUM must lie above the causes and fit NUM_W");
   end

   logic [NC-1:0] pend_q, gmask, cand;
   logic          nmi_q, hit;
   logic [CW-1:0] sel;

   irq_pend_reg #(.NUM_LOCAL(NUM_LOCAL), .NUM_W(NUM_W), .NMI_NUM(NMI_NUM)) u_pend (
      .clk(clk), .rst(rst),
      .post_valid(post_valid), .post_num(post_num),
      .clr_valid(clr_valid), .clr_num(clr_num), .clr_all(clr_all),
      .local_pin(local_pin), .pend_q(pend_q), .nmi_q(nmi_q)
   );

   irq_mask_gen #(.NUM_LOCAL(NUM_LOCAL)) u_mask (
      .lvl(lvl_t'(priv_lvl)), .st_mie(st_mie), .st_sie(st_sie), .st_uie(st_uie),
      .has_s(has_s), .has_n(has_n), .mdeleg(mdeleg), .sdeleg(sdeleg),
      .gmask(gmask), .bad_lvl(priv_err)
   );

   assign cand = pend_q & irq_en & gmask;

   irq_prio_sel #(.NUM_LOCAL(NUM_LOCAL)) u_sel (
      .cand(cand), .hit(hit), .sel(sel)
   );

   assign irq_nmi   = nmi_q;
   assign irq_valid = nmi_q | hit;
   assign irq_cause = nmi_q ? '0 : sel;
endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk #(
   parameter int NUM_LOCAL = 48,
   parameter int NUM_W     = 7,
   parameter int NMI_NUM   = 64,
   localparam int NC       = 16 + NUM_LOCAL,
   localparam int CW       = $clog2(NC)
) (
   input logic                 clk,
   input logic                 rst,
   input logic [1:0]           priv_lvl,
   input logic                 st_mie,
   input logic [NC-1:0]        irq_en,
   input logic                 post_valid,
   input logic [NUM_W-1:0]     post_num,
   input logic                 clr_all,
   input logic                 irq_valid,
   input logic                 irq_nmi,
   input logic [CW-1:0]        irq_cause,
   input logic                 priv_err
);
   localparam logic [15:0] USR_SUP = 16'h0333;

   assert_mach_closed_R1: assert property (@(posedge clk) disable iff (rst)
      (priv_lvl == 2'b11 && !st_mie) |-> (!irq_valid || irq_nmi));

   assert_mach_noclass_R1: assert property (@(posedge clk) disable iff (rst)
      (priv_lvl == 2'b11 && irq_valid && !irq_nmi && irq_cause < CW'(16))
         |-> !USR_SUP[irq_cause[3:0]]);

   assert_super_nouser_R2: assert property (@(posedge clk) disable iff (rst)
      (priv_lvl == 2'b01 && irq_valid && !irq_nmi)
         |-> !(irq_cause == CW'(0) || irq_cause == CW'(4) || irq_cause == CW'(8)));

   assert_nmi_first_R6: assert property (@(posedge clk) disable iff (rst)
      (post_valid && post_num == NUM_W'(NMI_NUM) && !clr_all)
         |=> (irq_valid && irq_nmi && irq_cause == '0));

   assert_enabled_R7: assert property (@(posedge clk) disable iff (rst)
      (irq_valid && !irq_nmi) |-> irq_en[irq_cause]);

   assert_clear_all_R10: assert property (@(posedge clk) disable iff (rst)
      clr_all |=> !irq_valid);

   assert_rsvd_R11: assert property (@(posedge clk) disable iff (rst)
      (priv_lvl == 2'b10) |-> (priv_err && irq_valid == irq_nmi));

   assert_rsvd_only_R11: assert property (@(posedge clk) disable iff (rst)
      (priv_lvl != 2'b10) |-> !priv_err);
endmodule

bind irq_arbiter irq_arbiter_chk #(
   .NUM_LOCAL(NUM_LOCAL), .NUM_W(NUM_W), .NMI_NUM(NMI_NUM)
) u_chk (
   .clk(clk), .rst(rst), .priv_lvl(priv_lvl), .st_mie(st_mie),
   .irq_en(irq_en), .post_valid(post_valid), .post_num(post_num),
   .clr_all(clr_all), .irq_valid(irq_valid), .irq_nmi(irq_nmi),
   .irq_cause(irq_cause), .priv_err(priv_err)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;
   localparam int NL = 48;
   localparam int NC = 64;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    priv_lvl = 2'b11;
   logic          st_mie = 0, st_sie = 0, st_uie = 0, has_s = 1, has_n = 1;
   logic [NC-1:0] mdeleg = '0, sdeleg = '0, irq_en = '0;
   logic          post_valid = 0, clr_valid = 0, clr_all = 0;
   logic [6:0]    post_num = '0, clr_num = '0;
   logic [NL-1:0] local_pin = '0;
   logic          irq_valid, irq_nmi, priv_err;
   logic [5:0]    irq_cause;

   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_arbiter u_dut (
      .clk(clk), .rst(rst), .priv_lvl(priv_lvl), .st_mie(st_mie), .st_sie(st_sie),
      .st_uie(st_uie), .has_s(has_s), .has_n(has_n), .mdeleg(mdeleg),
      .sdeleg(sdeleg), .irq_en(irq_en), .post_valid(post_valid),
      .post_num(post_num), .clr_valid(clr_valid), .clr_num(clr_num),
      .clr_all(clr_all), .local_pin(local_pin), .irq_valid(irq_valid),
      .irq_nmi(irq_nmi), .irq_cause(irq_cause), .priv_err(priv_err)
   );

   typedef struct packed {
      logic [1:0]  pl;
      logic        mie, sie, uie, hs, hn;
      logic [63:0] md, sd, en;
      logic        v;
      logic [5:0]  c;
   } vec_t;

   localparam logic [63:0] ALL = '1;
   localparam int NV = 26;
   localparam vec_t TBL [NV] = '{
      '{3,1,0,0,1,1,0,0,ALL,1,11},                      // R1
      '{3,0,0,0,1,1,0,0,ALL,0,0},                       // R1 closed
      '{3,1,0,0,1,1,0,0,64'h1_0333,1,16},               // R1 S/U ignored
      '{3,1,0,0,1,1,0,0,64'h333,0,0},                   // R1
      '{1,0,0,0,1,1,0,0,ALL,1,11},                      // R2
      '{1,0,0,0,1,1,64'h888,0,64'hAAA,0,0},             // R2
      '{1,0,1,0,1,1,64'h888,0,64'h888,1,11},            // R2
      '{1,0,1,0,1,1,0,0,64'h222,1,9},                   // R2
      '{1,0,1,0,1,1,0,0,64'h111,0,0},                   // R2
      '{1,0,0,0,1,1,64'h1_0000,0,64'h11_0000,1,20},     // R2 local
      '{0,0,0,0,1,1,0,64'h222,64'h333,0,0},             // R3
      '{0,0,0,0,1,1,0,64'h200,64'h222,1,1},             // R3
      '{0,0,0,1,1,1,0,64'h222,64'h111,1,8},             // R3
      '{0,0,0,0,1,0,64'h888,64'h888,64'h888,1,11},      // R5
      '{0,0,0,0,0,0,64'h888,64'h888,64'h888,1,11},      // R5
      '{0,0,0,0,0,1,64'h888,0,64'hAAA,0,0},             // R4
      '{0,0,0,1,0,1,64'h888,0,64'h888,1,11},            // R4
      '{0,0,0,1,0,1,0,0,64'h222,0,0},                   // R4
      '{1,0,0,0,0,0,64'h888,0,64'h888,1,11},            // R5
      '{2,1,1,1,1,1,0,0,ALL,0,0},                       // R11
      '{3,1,0,0,1,1,0,0,64'h88,1,3},                    // R7
      '{3,1,0,0,1,1,0,0,64'h80,1,7},                    // R7
      '{0,0,0,1,1,1,0,0,64'h11,1,0},                    // R7
      '{3,1,0,0,1,1,0,0,64'h8000_0000_0010_0000,1,20},  // R7
      '{3,1,0,0,1,1,0,0,64'h4,0,0},                     // R7 not pending
      '{0,0,0,0,0,1,64'h10_0000,0,64'h8000_0000_0010_0000,1,63} // R4 local
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic post(input logic [6:0] n);
      @(negedge clk); post_valid = 1; post_num = n;
      @(negedge clk); post_valid = 0;
   endtask

   task automatic clear(input logic [6:0] n);
      @(negedge clk); clr_valid = 1; clr_num = n;
      @(negedge clk); clr_valid = 0;
   endtask

   task automatic mach_open(input logic [63:0] en);
      priv_lvl = 2'b11; st_mie = 1; has_s = 1; has_n = 1;
      mdeleg = '0; sdeleg = '0; irq_en = en;
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      mach_open(ALL);
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk("R12 reset valid", irq_valid, 0);
      chk("R12 reset nmi", irq_nmi, 0);

      foreach (TBL[i]) ;
      post(0); post(1); post(3); post(4); post(5); post(7);
      post(8); post(9); post(11); post(16); post(20); post(63);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         priv_lvl = TBL[i].pl; st_mie = TBL[i].mie; st_sie = TBL[i].sie;
         st_uie = TBL[i].uie; has_s = TBL[i].hs; has_n = TBL[i].hn;
         mdeleg = TBL[i].md; sdeleg = TBL[i].sd; irq_en = TBL[i].en;
         #1;
         chk($sformatf("R7 row %0d valid", i), irq_valid, TBL[i].v);
         if (TBL[i].v) chk($sformatf("R7 row %0d cause", i), irq_cause, TBL[i].c);
         chk($sformatf("R11 row %0d err", i), priv_err, TBL[i].pl == 2'b10);
      end

      // R6: NMI over reserved level and closed mask
      @(negedge clk); priv_lvl = 2'b10; irq_en = '0;
      post(64);
      chk("R6 nmi valid", irq_valid, 1);
      chk("R6 nmi flag", irq_nmi, 1);
      chk("R6 nmi cause", irq_cause, 0);
      clear(64);
      chk("R9 nmi cleared", irq_nmi, 0);
      chk("R9 nmi cleared valid", irq_valid, 0);

      // R10 clear-all wipes pending and NMI, also against a pin
      post(64);
      @(negedge clk); mach_open(ALL); clr_all = 1; local_pin[2] = 1;
      @(negedge clk); clr_all = 0; local_pin[2] = 0;
      chk("R10 clear-all valid", irq_valid, 0);
      chk("R10 clear-all nmi", irq_nmi, 0);

      // R8 local pin 4 -> cause 20
      @(negedge clk); local_pin[4] = 1;
      @(negedge clk); local_pin[4] = 0;
      chk("R8 pin valid", irq_valid, 1);
      chk("R8 pin cause", irq_cause, 20);
      // pin beats a clear of the same cause
      @(negedge clk); local_pin[47] = 1; clr_valid = 1; clr_num = 63; irq_en = 64'h8000_0000_0000_0000;
      @(negedge clk); local_pin[47] = 0; clr_valid = 0;
      chk("R8 pin over clear", irq_cause, 63);

      // R9 post and clear same cause same cycle: post wins
      @(negedge clk); irq_en = 64'h800; clr_all = 1;
      @(negedge clk); clr_all = 0;
      @(negedge clk); post_valid = 1; post_num = 11; clr_valid = 1; clr_num = 11;
      @(negedge clk); post_valid = 0; clr_valid = 0;
      chk("R9 post over clear", irq_cause, 11);
      chk("R9 post over clear valid", irq_valid, 1);
      clear(11);
      chk("R9 clear", irq_valid, 0);
      // R9 out-of-range number ignored
      irq_en = ALL;
      post(70);
      chk("R9 out of range valid", irq_valid, 0);
      chk("R9 out of range nmi", irq_nmi, 0);

      // R12 reset drops pending state
      post(3);
      chk("R12 pre-reset", irq_cause, 3);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      @(negedge clk);
      chk("R12 after reset", irq_valid, 0);

      summary();
   end
endmodule